// File: doc/BRIEF.md
# Programmable-Increment Fractional Clock

This block keeps a 64-bit system time whose least significant bit is 2^-19 ns. An increment register holds two fields. The low 24 bits are an increment value that is added to the time at every update. The 8 bits above them are a period that sets how many base clock cycles separate two updates. At reset the period is 1 and the increment is 16 << 19 (0x800000). With a 16 ns base clock, the bits above the fraction then count nanoseconds. The low time word carries 19 fraction bits under 13 integer nanosecond bits. Together with the 32-bit high word this gives 45 significant nanosecond bits, and that nanosecond view wraps after roughly 9.8 hours.

Software reaches the time and the increment register through a plain word-wide register port. Reading the low time word captures the upper half at the same instant, so the next high-word read returns a coherent pair. Writing works the other way round. A low-word write only stages the value. The following high-word write loads both halves into the counter in one cycle.

The port is a control path and has no valid/ready handshake. A read is requested by holding `rd_en` for one cycle, and `rdata` holds the result from the next cycle until the next read. A write takes effect on the clock edge where `wr_en` is high.

Top module: `ftc_clock`

## Requirements
- R1: After reset the time is 0 and the increment register reads 0x01800000 (period field in bits 31:24 = 1, increment value in bits 23:0 = 0x800000).
- R2: With a period field of N > 0, the increment value is added to the time once every N base cycles, and the time holds its value between updates.
- R3: A period field of 0 stops the time completely.
- R4: A read of address 0 (low word) returns time bits 31:0 and captures time bits 63:32. A later read of address 1 (high word) returns that captured half, even if the time has moved on since the capture.
- R5: A write to address 0 only stages the low word and leaves the time unchanged. A write to address 1 loads the time with {written high word, staged low word} in a single cycle, and this load takes priority over an update on the same edge.
- R6: A write to address 2 (increment register) restarts the period count. The first update that uses the new value happens N edges after the write edge.
- R7: The time wraps modulo 2^64 with no flag, and carries pass from the low word into the high word.
- R8: With the reset setting the time advances by 0x800000 per cycle, so time bits 31:19 count 16 ns per base cycle.
- R9: A read returns its data in `rdata` on the cycle after `rd_en`. A read of address 2 returns the increment register. Address 3 reads as 0 and ignores writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for `addr`/`wdata` |
| rd_en | input | 1 | Read strobe for `addr` |
| addr | input | 2 | Word select: 0 time low, 1 time high, 2 increment register, 3 unused |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid the cycle after `rd_en` |

## Verification
The bound checker watches the counter on every cycle. It checks that each update adds exactly the increment value and that the time holds between updates. It also checks that a zero period never yields an update, that a high-word write loads {data, staged low word}, that a low-then-high read pair returns the upper half of the time at the moment of the low read, and that an increment write with a period other than 1 is followed by a quiet cycle. Some behaviour can only be shown by the bench's scenarios, because it depends on counting whole update intervals. This covers the exact number of updates in a window for several periods, the restart of the period count on a register write, wrap-around across 2^64, carries between the words, and the reset contents.

// File: rtl/ftc_pkg.sv
package ftc_pkg;
  // Register port word map; positions of the increment fields are fixed by
  // the increment register layout (value low, period directly above it).
  typedef enum logic [1:0] {
    ADDR_TIME_LO = 2'd0,
    ADDR_TIME_HI = 2'd1,
    ADDR_INCR    = 2'd2,
    ADDR_UNUSED  = 2'd3
  } ftc_addr_e;
endpackage

// File: rtl/ftc_incr_ctl.sv
// Increment register and the period timer that paces updates.
module ftc_incr_ctl #(
  parameter int WORD_W  = 32,
  parameter int VAL_W   = 24,
  parameter int PER_W   = 8,
  parameter int RST_PER = 1,
  parameter int RST_VAL = 16 << 19
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [WORD_W-1:0] wdata,
  output logic [PER_W-1:0]  period_o,
  output logic [VAL_W-1:0]  incval_o,
  output logic [WORD_W-1:0] reg_word_o,
  output logic              tick_o
);
  logic [PER_W-1:0] per_q;
  logic [PER_W-1:0] cnt_q;
  logic [VAL_W-1:0] val_q;

  // An update falls on the edge where the count reaches period-1.
  assign tick_o = (per_q != '0) && (cnt_q == per_q - PER_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      per_q <= PER_W'(RST_PER);
      val_q <= VAL_W'(RST_VAL);
      cnt_q <= '0;
    end else if (wr_en) begin
      per_q <= wdata[VAL_W +: PER_W];
      val_q <= wdata[VAL_W-1:0];
      cnt_q <= '0;
    end else if (per_q != '0) begin
      cnt_q <= tick_o ? '0 : cnt_q + PER_W'(1);
    end
  end

  always_comb begin
    reg_word_o                = '0;
    reg_word_o[VAL_W-1:0]     = val_q;
    reg_word_o[VAL_W +: PER_W] = per_q;
  end

  assign period_o = per_q;
  assign incval_o = val_q;
endmodule

// File: rtl/ftc_time_acc.sv
// The system time accumulator: load has priority over an update.
module ftc_time_acc #(
  parameter int CNT_W = 64,
  parameter int VAL_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic [VAL_W-1:0] incval,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic [CNT_W-1:0] time_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      time_o <= '0;
    else if (load)
      time_o <= load_val;
    else if (tick)
      time_o <= time_o + CNT_W'(incval);
  end
endmodule

// File: rtl/ftc_word_port.sv
// Word-wide register port with read capture and write staging.
module ftc_word_port
  import ftc_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int CNT_W  = 2 * WORD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en,
  input  logic              wr_en,
  input  logic [1:0]        addr,
  input  logic [WORD_W-1:0] wdata,
  input  logic [CNT_W-1:0]  time_i,
  input  logic [WORD_W-1:0] reg_word_i,
  output logic [WORD_W-1:0] rdata,
  output logic              load_o,
  output logic [CNT_W-1:0]  load_val_o,
  output logic              incr_wr_o,
  output logic [WORD_W-1:0] stage_lo_o,
  output logic [WORD_W-1:0] hi_cap_o
);
  ftc_addr_e sel;
  assign sel = ftc_addr_e'(addr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata    <= '0;
      hi_cap_o <= '0;
    end else if (rd_en) begin
      case (sel)
        ADDR_TIME_LO: begin
          rdata    <= time_i[WORD_W-1:0];
          hi_cap_o <= time_i[CNT_W-1:WORD_W];
        end
        ADDR_TIME_HI: rdata <= hi_cap_o;
        ADDR_INCR:    rdata <= reg_word_i;
        default:      rdata <= '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      stage_lo_o <= '0;
    else if (wr_en && sel == ADDR_TIME_LO)
      stage_lo_o <= wdata;
  end

  assign load_o     = wr_en && (sel == ADDR_TIME_HI);
  assign load_val_o = {wdata, stage_lo_o};
  assign incr_wr_o  = wr_en && (sel == ADDR_INCR);
endmodule

// File: rtl/ftc_clock.sv
// Programmable-increment fractional clock, top level.
module ftc_clock #(
  parameter int WORD_W  = 32,
  parameter int VAL_W   = 24,
  parameter int PER_W   = 8,
  parameter int RST_PER = 1,
  parameter int RST_VAL = 16 << 19
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [1:0]        addr,
  input  logic [WORD_W-1:0] wdata,
  output logic [WORD_W-1:0] rdata
);
  localparam int CNT_W = 2 * WORD_W;

  logic              tick;
  logic [PER_W-1:0]  period;
  logic [VAL_W-1:0]  incval;
  logic [WORD_W-1:0] reg_word;
  logic              load;
  logic [CNT_W-1:0]  load_val;
  logic              incr_wr;
  logic [WORD_W-1:0] stage_lo;
  logic [WORD_W-1:0] hi_cap;
  logic [CNT_W-1:0]  time_q;

  ftc_word_port #(.WORD_W(WORD_W), .CNT_W(CNT_W)) u_port (
    .clk        (clk),
    .rst_n      (rst_n),
    .rd_en      (rd_en),
    .wr_en      (wr_en),
    .addr       (addr),
    .wdata      (wdata),
    .time_i     (time_q),
    .reg_word_i (reg_word),
    .rdata      (rdata),
    .load_o     (load),
    .load_val_o (load_val),
    .incr_wr_o  (incr_wr),
    .stage_lo_o (stage_lo),
    .hi_cap_o   (hi_cap)
  );

  ftc_incr_ctl #(
    .WORD_W(WORD_W), .VAL_W(VAL_W), .PER_W(PER_W),
    .RST_PER(RST_PER), .RST_VAL(RST_VAL)
  ) u_incr (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (incr_wr),
    .wdata      (wdata),
    .period_o   (period),
    .incval_o   (incval),
    .reg_word_o (reg_word),
    .tick_o     (tick)
  );

  ftc_time_acc #(.CNT_W(CNT_W), .VAL_W(VAL_W)) u_acc (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick),
    .incval   (incval),
    .load     (load),
    .load_val (load_val),
    .time_o   (time_q)
  );
endmodule

// File: rtl/ftc_clock_chk.sv
// Property checker, attached to every ftc_clock instance.
module ftc_clock_chk #(
  parameter int WORD_W = 32,
  parameter int VAL_W  = 24,
  parameter int PER_W  = 8,
  parameter int CNT_W  = 2 * WORD_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic              rd_en,
  input logic [1:0]        addr,
  input logic [WORD_W-1:0] wdata,
  input logic [WORD_W-1:0] rdata,
  input logic [CNT_W-1:0]  time_q,
  input logic              tick,
  input logic [VAL_W-1:0]  incval,
  input logic [PER_W-1:0]  period,
  input logic [WORD_W-1:0] stage_lo
);
  logic             hi_load;
  logic             rd_lo;
  logic             rd_hi;
  logic [WORD_W-1:0] time_hi;
  assign hi_load = wr_en && addr == 2'd1;
  assign rd_lo   = rd_en && addr == 2'd0;
  assign rd_hi   = rd_en && addr == 2'd1;
  assign time_hi = time_q[CNT_W-1:WORD_W];

  // R2 / R7: each update adds exactly the increment, modulo 2^64
  p_step_adds_inc_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !hi_load) |=> time_q == $past(time_q) + CNT_W'($past(incval)));

  // R2: no update and no load means the time holds
  p_hold_between_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !hi_load) |=> $stable(time_q));

  // R3: a zero period never produces an update
  p_zero_period_stops_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (period == '0) |-> !tick);

  // R5: high-word write loads both halves at once
  p_atomic_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
    hi_load |=> time_q == {$past(wdata), $past(stage_lo)});

  // R4: low read then high read returns the upper half seen at the low read
  p_coherent_pair_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_lo ##1 rd_hi |=> rdata == $past(time_hi, 2));

  // R6: increment write restarts the count, so no update follows unless period is 1
  p_restart_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 2'd2 && wdata[VAL_W +: PER_W] != PER_W'(1)) |=> !tick);
endmodule

bind ftc_clock ftc_clock_chk #(
  .WORD_W(WORD_W), .VAL_W(VAL_W), .PER_W(PER_W), .CNT_W(2 * WORD_W)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .wr_en    (wr_en),
  .rd_en    (rd_en),
  .addr     (addr),
  .wdata    (wdata),
  .rdata    (rdata),
  .time_q   (time_q),
  .tick     (tick),
  .incval   (incval),
  .period   (period),
  .stage_lo (stage_lo)
);

// File: tb/tb_ftc_clock.sv
`timescale 1ns/1ps
module tb_ftc_clock;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [1:0]  addr = 2'd0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  ftc_clock dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata)
  );

  typedef struct packed {
    logic [7:0]  per;
    logic [23:0] val;
    logic [63:0] load;
    logic [15:0] idle;
    logic [63:0] expv;
  } vec_t;

  // expected = load + floor(idle/per) * val (mod 2^64), or load when per = 0
  localparam vec_t VECS [7] = '{
    '{8'd1,   24'h800000, 64'h0,                  16'd10,  64'h0000_0000_0500_0000}, // R8 nominal
    '{8'd4,   24'h000100, 64'h0000_0000_0000_1000, 16'd10,  64'h0000_0000_0000_1200}, // R2
    '{8'd0,   24'hFFFFFF, 64'h1234_5678_9ABC_DEF0, 16'd8,   64'h1234_5678_9ABC_DEF0}, // R3
    '{8'd3,   24'hFFFFFF, 64'h0000_0001_FFFF_FFFF, 16'd9,   64'h0000_0002_02FF_FFFC}, // R7 carry
    '{8'd1,   24'h800000, 64'hFFFF_FFFF_FFC0_0000, 16'd1,   64'h0000_0000_0040_0000}, // R7 wrap
    '{8'd255, 24'h000005, 64'h0000_0000_0000_0077, 16'd254, 64'h0000_0000_0000_0077}, // R2 edge
    '{8'd2,   24'hABCDEF, 64'h0,                  16'd7,   64'h0000_0000_0203_69CD}  // R2
  };

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got=%h expected=%h", req, got, exp);
    end
  endtask

  // Each access task starts at a falling edge and covers exactly one rising edge.
  task automatic do_wr(input logic [1:0] a, input logic [31:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic do_rd(input logic [1:0] a, output logic [31:0] d);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    d = rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic load_time(input logic [63:0] v);
    do_wr(2'd2, 32'h0);
    do_wr(2'd0, v[31:0]);
    do_wr(2'd1, v[63:32]);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: got=timeout expected=completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state and R8 nominal rate straight out of reset
    do_rd(2'd0, d); check("R1 time low after reset", d, 32'h0);
    do_rd(2'd1, d); check("R1 time high after reset", d, 32'h0);
    do_rd(2'd0, d); check("R8 two nominal updates", d, 32'h0100_0000);
    check("R8 ns field counts 16/cycle", {19'b0, d[31:19]}, 32'd32);
    do_rd(2'd2, d); check("R1 R9 increment register reset", d, 32'h0180_0000);

    // Vector table
    foreach (VECS[i]) begin
      load_time(VECS[i].load);
      do_wr(2'd2, {VECS[i].per, VECS[i].val});
      idle(int'(VECS[i].idle));
      do_rd(2'd0, d); check($sformatf("R2 vec%0d low", i), d, VECS[i].expv[31:0]);
      do_rd(2'd1, d); check($sformatf("R7 vec%0d high", i), d, VECS[i].expv[63:32]);
    end

    // R4: high half is captured at the low read while time crosses 2^32
    load_time(64'h0000_0000_FF80_0000);
    do_wr(2'd2, 32'h0180_0000);
    do_rd(2'd0, d); check("R4 low before carry", d, 32'hFF80_0000);
    do_rd(2'd1, d); check("R4 high from capture", d, 32'h0);
    do_rd(2'd0, d); check("R4 low after carry", d, 32'h0080_0000);
    do_rd(2'd1, d); check("R4 high after carry", d, 32'h1);

    // R5: low write only stages, high write loads both
    load_time(64'h0000_00AA_1111_2222);
    do_wr(2'd0, 32'hDEAD_0000);
    do_rd(2'd0, d); check("R5 low write staged only", d, 32'h1111_2222);
    do_rd(2'd1, d); check("R5 high unchanged", d, 32'h0000_00AA);
    do_wr(2'd1, 32'h0000_0055);
    do_rd(2'd0, d); check("R5 low loaded", d, 32'hDEAD_0000);
    do_rd(2'd1, d); check("R5 high loaded", d, 32'h0000_0055);

    // R6: increment write restarts the period count
    load_time(64'h0);
    do_wr(2'd2, 32'h0400_0001);
    idle(2);
    do_wr(2'd2, 32'h0400_0010);
    idle(3);
    do_rd(2'd0, d); check("R6 no update before restart interval", d, 32'h0);
    do_rd(2'd0, d); check("R6 first update uses new value", d, 32'h0000_0010);

    // R9: unused address reads zero and ignores writes
    do_rd(2'd3, d); check("R9 unused reads zero", d, 32'h0);
    do_wr(2'd3, 32'hFFFF_FFFF);
    do_rd(2'd2, d); check("R9 increment register untouched", d, 32'h0400_0010);
    do_rd(2'd1, d); check("R9 time high untouched", d, 32'h0);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule